// File: doc/BRIEF.md
# Parallel Single-Ramp Conversion Sequencer

This block is the digital side of a converter in which one linear ramp and one counter are shared by every channel, and each channel supplies only a comparator output. The front end stays powered while the bunch train runs. When the train ends, the block resets the integrators and the ramp, cuts front-end power, and releases the ramp. A shared counter then advances once per clock for 1024 cycles. Each channel stores the count at which its comparator first rises.

After the ramp, the block steps through the channels in ascending order. It writes one word into the on-chip buffer for each channel that was flagged as triggered. It then restores front-end power, waits for the supply to settle, and resets the integrators again before it accepts the next train. The reset length and the settling length come from two inputs. A value of zero on either input is treated as one cycle.

Top module: `ramp_adc_seq`

## Requirements
- R1: While and after reset, `fePowerOn` is 1, and `intReset`, `rampReset`, `rampRun` and `bufWrEn` are all 0.
- R2: A `trainEnd` pulse in the idle state asserts `intReset` and `rampReset` with power still on for max(1, `rstCycles`) cycles. `fePowerOn` then falls.
- R3: With power off, `rampReset` stays high for max(1, `settleCycles`) cycles. Then `rampRun` is high for exactly 1024 cycles while the counter goes from 0 to 1023.
- R4: A channel stores the counter value of the ramp cycle in which its comparator is first seen high after being low. A comparator already high in the first ramp cycle gives code 0. Any later rising edge in the same ramp leaves the stored code unchanged.
- R5: A channel with no rising edge during the ramp is stored as code 1023 with its overflow flag set. A rise in the last ramp cycle gives 1023 with the flag clear.
- R6: The push phase takes one cycle per channel, in ascending index order. A word is written only for channels whose `trigIn` bit was 1 at the `trainEnd` pulse. The word is {channel index in bits [WORD_W-1:11], overflow flag in bit 10, code in bits [9:0]}.
- R7: After the push phase, `fePowerOn` rises and stays high with `intReset` low for max(1, `settleCycles`) cycles. `intReset` is then high for max(1, `rstCycles`) cycles, after which the block is idle.
- R8: `intReset` is never high while front-end power is off, and power is only removed directly after an integrator reset.
- R9: A `trainEnd` pulse outside the idle state has no effect: the current conversion runs to its normal length and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trainEnd | input | 1 | Pulse marking the end of the bunch train |
| trigIn | input | NUM_CH | Per-channel triggered flags, captured at `trainEnd` |
| cmpIn | input | NUM_CH | Per-channel comparator outputs |
| rstCycles | input | CNT_W | Length of the integrator reset, in cycles |
| settleCycles | input | CNT_W | Length of power and ramp settling, in cycles |
| fePowerOn | output | 1 | Front-end power enable |
| intReset | output | 1 | Integrator reset |
| rampReset | output | 1 | Holds the ramp at its start level |
| rampRun | output | 1 | Ramp running, counter active |
| bufWrEn | output | 1 | Output buffer write strobe |
| bufData | output | WORD_W | Output buffer word |

## Verification
Three events can collide in a single cycle of the last ramp step: the counter reaching its end, a comparator rising, and the forced overflow entry. One channel is placed to rise exactly at count 1023 and another never rises. The first must come out as 1023 with the flag clear and the second as 1023 with the flag set. A second collision comes from raising a `trainEnd` pulse in the middle of the ramp. It is judged by the ramp still lasting 1024 cycles, the sequence returning to idle once, and the written words matching the table. Every firing comparator also falls and rises again after its first edge, and the stored code must not move.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  localparam int CODE_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RESET, ST_POWER_DOWN, ST_RAMP, ST_PUSH, ST_POWER_UP
  } seqState_t;

  typedef struct packed {
    logic              capture;
    logic              clear;
    logic              rampOn;
    logic              rampLast;
    logic [CODE_W-1:0] rampCode;
    logic              pushOn;
  } seqStrobe_t;
endpackage

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trainEnd,
  input  logic [CNT_W-1:0] rstCycles,
  input  logic [CNT_W-1:0] settleCycles,
  output seqStrobe_t       strb,
  output logic [CH_W-1:0]  pushIdx,
  output logic             fePowerOn,
  output logic             intReset,
  output logic             rampReset,
  output logic             rampRun
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CH_W-1:0]   LAST_CH  = CH_W'(NUM_CH - 1);

  seqState_t         state;
  logic [CNT_W-1:0]  waitCnt;
  logic [CODE_W-1:0] rampCnt;
  logic [CH_W-1:0]   pushPtr;
  logic              upPhase;
  logic [CNT_W-1:0]  rstLen, setLen;
  logic              rstDone, setDone;

  assign rstLen  = (rstCycles == '0) ? CNT_W'(1) : rstCycles;
  assign setLen  = (settleCycles == '0) ? CNT_W'(1) : settleCycles;
  assign rstDone = (waitCnt >= rstLen - CNT_W'(1));
  assign setDone = (waitCnt >= setLen - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      rampCnt <= '0;
      pushPtr <= '0;
      upPhase <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (trainEnd) begin
          state   <= ST_RESET;
          waitCnt <= '0;
        end
        ST_RESET: if (rstDone) begin
          state   <= ST_POWER_DOWN;
          waitCnt <= '0;
        end else waitCnt <= waitCnt + CNT_W'(1);
        ST_POWER_DOWN: if (setDone) begin
          state   <= ST_RAMP;
          rampCnt <= '0;
        end else waitCnt <= waitCnt + CNT_W'(1);
        ST_RAMP: if (rampCnt == CODE_MAX) begin
          state   <= ST_PUSH;
          pushPtr <= '0;
        end else rampCnt <= rampCnt + CODE_W'(1);
        ST_PUSH: if (pushPtr == LAST_CH) begin
          state   <= ST_POWER_UP;
          waitCnt <= '0;
          upPhase <= 1'b0;
        end else pushPtr <= pushPtr + CH_W'(1);
        ST_POWER_UP: if (!upPhase) begin
          if (setDone) begin
            upPhase <= 1'b1;
            waitCnt <= '0;
          end else waitCnt <= waitCnt + CNT_W'(1);
        end else if (rstDone) state <= ST_IDLE;
        else waitCnt <= waitCnt + CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture  = (state == ST_IDLE) && trainEnd;
    strb.clear    = (state == ST_POWER_DOWN);
    strb.rampOn   = (state == ST_RAMP);
    strb.rampLast = (state == ST_RAMP) && (rampCnt == CODE_MAX);
    strb.rampCode = rampCnt;
    strb.pushOn   = (state == ST_PUSH);
  end

  assign pushIdx   = pushPtr;
  assign fePowerOn = !(state inside {ST_POWER_DOWN, ST_RAMP, ST_PUSH});
  assign intReset  = (state == ST_RESET) || ((state == ST_POWER_UP) && upPhase);
  assign rampReset = (state == ST_RESET) || (state == ST_POWER_DOWN);
  assign rampRun   = (state == ST_RAMP);

  AST_RST_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fePowerOn) |-> $past(intReset)); // R8
  AST_NO_RST_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    intReset |-> fePowerOn); // R8
  AST_RAMP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rampRun) |-> ($past(rampCnt) == CODE_MAX)); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_RESET) |=> (state != ST_RESET)); // R9
endmodule

// File: rtl/ramp_adc_dp.sv
module ramp_adc_dp
  import ramp_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W = CH_W + 1 + CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [CH_W-1:0]   pushIdx,
  input  logic [NUM_CH-1:0] trigIn,
  input  logic [NUM_CH-1:0] cmpIn,
  output logic              bufWrEn,
  output logic [WORD_W-1:0] bufData
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] codeR [NUM_CH];
  logic [NUM_CH-1:0] ovfR, doneR, cmpQ, trigQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeR[i] <= '0;
        ovfR[i]  <= 1'b0;
        doneR[i] <= 1'b0;
        cmpQ[i]  <= 1'b0;
      end else if (strb.clear) begin
        codeR[i] <= '0;
        ovfR[i]  <= 1'b0;
        doneR[i] <= 1'b0;
        cmpQ[i]  <= 1'b0;
      end else if (strb.rampOn) begin
        cmpQ[i] <= cmpIn[i];
        if (!doneR[i] && cmpIn[i] && !cmpQ[i]) begin
          codeR[i] <= strb.rampCode;
          doneR[i] <= 1'b1;
        end else if (!doneR[i] && strb.rampLast) begin
          codeR[i] <= CODE_MAX;
          ovfR[i]  <= 1'b1;
          doneR[i] <= 1'b1;
        end
      end
    end

    AST_FIRST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.rampOn && doneR[i]) |=> $stable(codeR[i])); // R4
    AST_OVF_FULL_SCALE: assert property (@(posedge clk) disable iff (!rstN)
      ovfR[i] |-> (codeR[i] == CODE_MAX)); // R5
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigQ <= '0;
    else if (strb.capture) trigQ <= trigIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufWrEn <= 1'b0;
      bufData <= '0;
    end else begin
      bufWrEn <= strb.pushOn && trigQ[pushIdx];
      bufData <= {pushIdx, ovfR[pushIdx], codeR[pushIdx]};
    end
  end

  AST_PUSH_ONLY_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushOn && !trigQ[pushIdx]) |=> !bufWrEn); // R6
  AST_WRITE_IN_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(strb.pushOn)); // R6
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W = CH_W + 1 + CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trainEnd,
  input  logic [NUM_CH-1:0] trigIn,
  input  logic [NUM_CH-1:0] cmpIn,
  input  logic [CNT_W-1:0]  rstCycles,
  input  logic [CNT_W-1:0]  settleCycles,
  output logic              fePowerOn,
  output logic              intReset,
  output logic              rampReset,
  output logic              rampRun,
  output logic              bufWrEn,
  output logic [WORD_W-1:0] bufData
);
  seqStrobe_t      strb;
  logic [CH_W-1:0] pushIdx;

  ramp_adc_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trainEnd(trainEnd),
    .rstCycles(rstCycles), .settleCycles(settleCycles),
    .strb(strb), .pushIdx(pushIdx),
    .fePowerOn(fePowerOn), .intReset(intReset),
    .rampReset(rampReset), .rampRun(rampRun)
  );

  ramp_adc_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushIdx(pushIdx),
    .trigIn(trigIn), .cmpIn(cmpIn),
    .bufWrEn(bufWrEn), .bufData(bufData)
  );
endmodule

// File: tb/sim_ramp_adc_seq.sv
module sim_ramp_adc_seq;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 8;
  localparam int WORD_W = 3 + 1 + 10;
  localparam int NV     = 3;
  localparam int NEVER  = 1024;

  localparam logic [10:0] TV_CODE [0:NV-1][0:NUM_CH-1] = '{
    '{11'd0, 11'd1, 11'd100, 11'd512, 11'd1022, 11'd1023, 11'd1024, 11'd7},
    '{11'd5, 11'd1024, 11'd300, 11'd300, 11'd40, 11'd999, 11'd2, 11'd1024},
    '{11'd10, 11'd10, 11'd10, 11'd10, 11'd10, 11'd10, 11'd10, 11'd10}
  };
  localparam logic [NUM_CH-1:0] TV_MASK [0:NV-1] = '{8'hFF, 8'hA5, 8'h00};
  localparam int TV_RST [0:NV-1] = '{3, 0, 2};
  localparam int TV_SET [0:NV-1] = '{2, 4, 0};
  localparam bit TV_MID [0:NV-1] = '{1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trainEnd = 1'b0;
  logic [NUM_CH-1:0] trigIn = '0;
  logic [NUM_CH-1:0] cmpIn = '0;
  logic [CNT_W-1:0] rstCycles = '0;
  logic [CNT_W-1:0] settleCycles = '0;
  logic fePowerOn, intReset, rampReset, rampRun, bufWrEn;
  logic [WORD_W-1:0] bufData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ramp_adc_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .trainEnd(trainEnd), .trigIn(trigIn),
    .cmpIn(cmpIn), .rstCycles(rstCycles), .settleCycles(settleCycles),
    .fePowerOn(fePowerOn), .intReset(intReset), .rampReset(rampReset),
    .rampRun(rampRun), .bufWrEn(bufWrEn), .bufData(bufData)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic runTrain(input int v);
    int pre = 0, down = 0, ramp = 0, setUp = 0, post = 0, rIdx = 0, nGot = 0, nExp = 0;
    int rl, sl;
    bit seenDown = 0, rstLow = 1;
    logic [WORD_W-1:0] got [0:15];
    rl = (TV_RST[v] == 0) ? 1 : TV_RST[v];
    sl = (TV_SET[v] == 0) ? 1 : TV_SET[v];
    rstCycles = CNT_W'(TV_RST[v]);
    settleCycles = CNT_W'(TV_SET[v]);
    trigIn = TV_MASK[v];
    cmpIn = '0;
    trainEnd = 1'b1;
    @(negedge clk);
    trainEnd = 1'b0;
    trigIn = '0;
    for (int k = 0; k < 5000; k++) begin
      if (!seenDown && fePowerOn && !intReset) rstLow = 0;
      if (intReset && fePowerOn && !seenDown) pre++;
      if (!fePowerOn) begin
        seenDown = 1;
        down++;
      end
      if (seenDown && fePowerOn) begin
        if (intReset) post++;
        else if (post == 0) setUp++;
        else break;
      end
      if (bufWrEn && nGot < 16) begin
        got[nGot] = bufData;
        nGot++;
      end
      trainEnd = 1'b0;
      if (rampRun) begin
        ramp++;
        for (int c = 0; c < NUM_CH; c++) begin
          int t = int'(TV_CODE[v][c]);
          if (t == rIdx) cmpIn[c] = 1'b1;
          if (t != NEVER && rIdx == t + 3) cmpIn[c] = 1'b0;
          if (t != NEVER && rIdx == t + 6) cmpIn[c] = 1'b1;
        end
        if (TV_MID[v] && rIdx == 500) trainEnd = 1'b1;
        rIdx++;
      end
      @(negedge clk);
    end
    chk("R2", "integrator reset length before power-off", pre, rl);
    chk("R2", "reset held continuously before power-off", int'(rstLow), 1);
    chk("R3", "power-off span", down, sl + 1024 + NUM_CH);
    chk("R3", "ramp length", ramp, 1024);
    chk("R9", "ramp length with stray trainEnd", ramp, 1024);
    chk("R7", "settle after power-up", setUp, sl);
    chk("R7", "integrator reset after power-up", post, rl);
    for (int c = 0; c < NUM_CH; c++) if (TV_MASK[v][c]) nExp++;
    chk("R6", "words written", nGot, nExp);
    nExp = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (TV_MASK[v][c]) begin
        int t = int'(TV_CODE[v][c]);
        logic [WORD_W-1:0] e;
        e = (t == NEVER) ? {3'(c), 1'b1, 10'd1023} : {3'(c), 1'b0, 10'(t)};
        if (nExp < nGot) begin
          chk((t == NEVER) ? "R5" : "R4", "word (R6 format)", int'(got[nExp]), int'(e));
        end
        nExp++;
      end
    end
    cmpIn = '0;
    repeat (5) begin
      @(negedge clk);
      chk("R9", "no second conversion after stray trainEnd", int'(rampRun | intReset), 0);
    end
  endtask

  initial begin
    @(negedge clk);
    chk("R1", "fePowerOn in reset", int'(fePowerOn), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "fePowerOn after reset", int'(fePowerOn), 1);
    chk("R1", "intReset after reset", int'(intReset), 0);
    chk("R1", "rampReset after reset", int'(rampReset), 0);
    chk("R1", "rampRun after reset", int'(rampRun), 0);
    chk("R1", "bufWrEn after reset", int'(bufWrEn), 0);
    for (int v = 0; v < NV; v++) runTrain(v);
    // R8: power stays on while idle with comparators toggling
    cmpIn = '1;
    repeat (3) @(negedge clk);
    chk("R8", "power idle with comparators high", int'(fePowerOn), 1);
    chk("R4", "no write while idle", int'(bufWrEn), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule